// File: doc/BRIEF.md
# Misaligned Little-Endian Load/Store Unit

This block stands between a processor pipeline and a 32-bit word memory whose addresses count bytes. The core hands it one load or store at a time, 1, 2 or 4 bytes wide, at any byte address. The unit turns that request into word transactions with per-byte write enables. For loads it gathers the returned bytes in little-endian order, so the lowest address holds the least significant byte. It then widens the result to 32 bits with either zero or sign fill.

An access that spills past the end of its 32-bit word is not a fault. The unit issues two word transactions, the lower address first, and joins the two halves. This costs at least one extra memory handshake. An optional swap flag reverses the four bytes of the value, which lets software handle data stored in the opposite byte order.

The memory side is a plain synchronous word port. A request stays asserted and unchanged until the memory raises its ready flag, and read data is taken in that same cycle. The core sees a busy flag for the whole operation and exactly one response pulse at its end.

Top module: `lsu_misalign`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy`, `rsp_valid` and `mem_valid` are low.
- R2: A request is taken at a clock edge where `req_valid` is high and `busy` is low, and `busy` is high from the next cycle on. A request presented while `busy` is high is ignored: it causes no memory transaction and changes no memory byte.
- R3: An access whose bytes all lie in one aligned word makes exactly one memory transaction. Its `mem_addr` is the request address with bits 1:0 cleared.
- R4: An access whose last byte lies in the following word makes exactly two transactions. The first is at the lower word and the second at that word address plus 4, wrapping modulo 2^32.
- R5: `mem_be` bit i enables byte lane i, which is `mem_wdata[8i+7:8i]`. A store enables exactly the lanes its bytes occupy and writes byte k of its value to address addr+k. No other memory byte changes.
- R6: Load bytes are assembled little-endian: the byte at address addr+k becomes bits 8k+7:8k of the result, including across a word boundary.
- R7: `req_size` selects 1 byte (0), 2 bytes (1) or 4 bytes (2 and 3). With `req_signed` low the bits above the loaded bytes are 0. With it high they copy the top bit of the loaded bytes.
- R8: With `req_swap` high, a load returns its extended 32-bit result with the four bytes reversed. A store takes the low bytes of its write data after reversing the four bytes.
- R9: Each accepted request produces exactly one one-cycle `rsp_valid` pulse, in the cycle after the final transaction's `mem_ready`. In that same cycle `busy` is low.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_be` and `mem_wdata` hold their values into the next cycle.
- R11: `mem_write` is high on every transaction of a store and low on every transaction of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 = byte, 1 = half, 2/3 = word |
| req_signed | input | 1 | Sign-extend a load |
| req_swap | input | 1 | Reverse the four bytes of the value |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, low bytes used |
| busy | output | 1 | Operation in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load result, zero for stores |
| mem_valid | output | 1 | Word transaction request |
| mem_write | output | 1 | Transaction is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Write data by lane |
| mem_ready | input | 1 | Memory accepts / returns this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |

## Verification
The embedded assertions watch the handshake on every cycle. They check that requests hold still under back-pressure, that every transaction is word-aligned with at least one lane enabled, that a second beat always targets the next word, and that the response is a single pulse with `busy` already low. Byte placement, sign and zero fill, the swap option, the ignoring of requests made while busy, and the absence of stray byte writes depend on data values and on memory contents. Only the bench's reference memory and its expected-value functions can show these, using random sizes, offsets and stalls together with directed wrap-around and boundary cases.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } lsu_state_t;
endpackage

// File: rtl/lsu_store_place.sv
module lsu_store_place #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0]    off,
  input  logic [BYTES-1:0]    keep,
  input  logic                swp,
  input  logic [DATA_W-1:0]   data,
  output logic [2*BYTES-1:0]  be2,
  output logic [2*DATA_W-1:0] wd2
);
  logic [DATA_W-1:0] src;

  // optional byte reversal before lane placement
  for (genvar i = 0; i < BYTES; i++) begin : g_rev
    assign src[8*i +: 8] = swp ? data[8*(BYTES-1-i) +: 8] : data[8*i +: 8];
  end

  // two-word window: low word is the first beat, high word the second
  assign be2 = {{BYTES{1'b0}}, keep} << off;
  assign wd2 = {{DATA_W{1'b0}}, src} << {off, 3'b000};
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  input  logic [OFF_W-1:0]  off,
  input  logic [BYTES-1:0]  keep,
  input  logic              sgn,
  input  logic              swp,
  output logic [DATA_W-1:0] value
);
  logic [2*DATA_W-1:0] win;
  logic [DATA_W-1:0]   raw;
  logic [DATA_W-1:0]   ext;
  logic [BYTES:0]      keep_x;
  logic [BYTES-1:0]    top_sb;
  logic                fill;

  assign win    = {hi, lo} >> {off, 3'b000};
  assign raw    = win[DATA_W-1:0];
  assign keep_x = {1'b0, keep};

  // sign bit comes from the highest kept byte
  for (genvar i = 0; i < BYTES; i++) begin : g_top
    assign top_sb[i] = keep_x[i] & ~keep_x[i+1] & raw[8*i+7];
  end
  assign fill = sgn & (|top_sb);

  for (genvar i = 0; i < BYTES; i++) begin : g_ext
    assign ext[8*i +: 8] = keep[i] ? raw[8*i +: 8] : {8{fill}};
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_swap
    assign value[8*i +: 8] = swp ? ext[8*(BYTES-1-i) +: 8] : ext[8*i +: 8];
  end
endmodule

// File: rtl/lsu_misalign.sv
module lsu_misalign #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int WA_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic              req_swap,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  import lsu_pkg::*;

  lsu_state_t          state;
  logic [WA_W-1:0]     word_q;
  logic [OFF_W-1:0]    off_q;
  logic [BYTES-1:0]    keep_q;
  logic                sgn_q, swp_q, wr_q;
  logic [2*BYTES-1:0]  be2_q;
  logic [2*DATA_W-1:0] wd2_q;
  logic [DATA_W-1:0]   lo_q;

  logic [BYTES-1:0]    req_keep;
  logic [2*BYTES-1:0]  be2_n;
  logic [2*DATA_W-1:0] wd2_n;
  logic [DATA_W-1:0]   ld_lo, ld_val;
  logic                split_q;
  logic                in_hi;

  // byte mask for a size code; codes beyond the width clamp to a full word
  always_comb begin
    int nb;
    nb = 1 << req_size;
    if (nb > BYTES) nb = BYTES;
    for (int i = 0; i < BYTES; i++) req_keep[i] = (i < nb);
  end

  lsu_store_place #(.DATA_W(DATA_W)) u_place (
    .off  (req_addr[OFF_W-1:0]),
    .keep (req_keep),
    .swp  (req_swap),
    .data (req_wdata),
    .be2  (be2_n),
    .wd2  (wd2_n)
  );

  assign ld_lo = (state == ST_LO) ? mem_rdata : lo_q;

  lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
    .lo    (ld_lo),
    .hi    (mem_rdata),
    .off   (off_q),
    .keep  (keep_q),
    .sgn   (sgn_q),
    .swp   (swp_q),
    .value (ld_val)
  );

  assign split_q = |be2_q[2*BYTES-1:BYTES];
  assign in_hi   = (state == ST_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      word_q    <= '0;
      off_q     <= '0;
      keep_q    <= '0;
      sgn_q     <= 1'b0;
      swp_q     <= 1'b0;
      wr_q      <= 1'b0;
      be2_q     <= '0;
      wd2_q     <= '0;
      lo_q      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          word_q <= req_addr[ADDR_W-1:OFF_W];
          off_q  <= req_addr[OFF_W-1:0];
          keep_q <= req_keep;
          sgn_q  <= req_signed;
          swp_q  <= req_swap;
          wr_q   <= req_write;
          be2_q  <= be2_n;
          wd2_q  <= wd2_n;
          state  <= ST_LO;
        end
        ST_LO: if (mem_ready) begin
          lo_q <= mem_rdata;
          if (split_q) begin
            state <= ST_HI;
          end else begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_rdata <= wr_q ? '0 : ld_val;
          end
        end
        ST_HI: if (mem_ready) begin
          state     <= ST_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= wr_q ? '0 : ld_val;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign mem_valid = (state != ST_IDLE);
  assign mem_write = wr_q;
  assign mem_addr  = {word_q + WA_W'(in_hi), {OFF_W{1'b0}}};
  assign mem_be    = in_hi ? be2_q[2*BYTES-1:BYTES] : be2_q[BYTES-1:0];
  assign mem_wdata = in_hi ? wd2_q[2*DATA_W-1:DATA_W] : wd2_q[DATA_W-1:0];

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!busy && !rsp_valid && !mem_valid));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  // R3
  word_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

  // R4
  next_word_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && $past(mem_valid && mem_ready)) |->
      (mem_addr == $past(mem_addr) + ADDR_W'(BYTES)));

  // R5
  lane_used_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_be != '0));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);

  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata)));

  // R11
  write_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && $past(mem_valid)) |-> $stable(mem_write));
endmodule

// File: tb/tb_lsu_misalign.sv
module tb_lsu_misalign;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0, req_swap = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        busy, rsp_valid, mem_valid, mem_write;
  logic [31:0] rsp_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        mem_ready = 1'b0;

  always #4 clk = ~clk;

  lsu_misalign dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_signed(req_signed), .req_swap(req_swap), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0;
  logic [7:0]  mdl [64];
  logic [7:0]  refm [64];
  logic        stall = 1'b0;
  int          nbeat = 0, rsp_cnt = 0;
  logic [31:0] beat_a [4];
  logic        beat_w [4];

  assign mem_rdata = {mdl[{mem_addr[5:2], 2'd3}], mdl[{mem_addr[5:2], 2'd2}],
                      mdl[{mem_addr[5:2], 2'd1}], mdl[{mem_addr[5:2], 2'd0}]};

  // memory model: accepts a beat at the edge where valid and ready meet
  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (nbeat < 4) begin
        beat_a[nbeat] = mem_addr;
        beat_w[nbeat] = mem_write;
      end
      nbeat = nbeat + 1;
      if (mem_write)
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mdl[{mem_addr[5:2], 2'(i)}] = mem_wdata[8*i +: 8];
    end
  end

  always @(negedge clk) begin
    mem_ready <= stall ? 1'b0 : ($urandom % 4 != 0);
    if (rsp_valid) rsp_cnt = rsp_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] exp_load(input logic [31:0] a, input logic [1:0] sz,
                                           input logic sg, sw);
    logic [31:0] v = '0;
    int n = nbytes(sz);
    for (int k = 0; k < n; k++) v[8*k +: 8] = refm[6'(a + 32'(k))];
    if (sg && v[8*n-1]) v = v | (32'hFFFF_FFFF << (8*n));
    return sw ? bswap(v) : v;
  endfunction

  task automatic run_op(input logic wr, input logic [1:0] sz, input logic sg, sw,
                        input logic [31:0] a, wd, input bit inject);
    int n = nbytes(sz);
    bit split = (int'(a[1:0]) + n) > 4;
    logic [31:0] w0 = {a[31:2], 2'b00};
    logic [31:0] expv = exp_load(a, sz, sg, sw);
    logic [31:0] sv = sw ? bswap(wd) : wd;
    logic [31:0] got;
    bit seen = 0, busy_at_rsp = 1;
    if (inject) begin
      stall = 1'b1;
      @(negedge clk);
    end
    @(negedge clk);
    rsp_cnt = 0; nbeat = 0;
    req_write = wr; req_size = sz; req_signed = sg; req_swap = sw;
    req_addr = a; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R2 busy after accept", 32'(busy), 1);
    if (inject) begin
      // a store to a far location while busy must be dropped
      req_write = 1'b1; req_size = 2'd2; req_addr = a + 32'd32;
      req_wdata = ~wd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      stall = 1'b0;
    end
    for (int t = 0; t < 200 && !seen; t++) begin
      @(negedge clk);
      if (rsp_valid) begin seen = 1; got = rsp_rdata; busy_at_rsp = busy; end
    end
    @(negedge clk);
    @(negedge clk);
    chk(seen, "R9 response seen", 32'(seen), 1);
    chk(rsp_cnt == 1, "R9 one pulse", 32'(rsp_cnt), 1);
    chk(!busy_at_rsp, "R9 busy low with response", 32'(busy_at_rsp), 0);
    if (split) begin
      chk(nbeat == 2, "R4 two beats", 32'(nbeat), 2);
      chk(beat_a[0] == w0, "R4 first beat low word", beat_a[0], w0);
      chk(beat_a[1] == w0 + 32'd4, "R4 second beat next word", beat_a[1], w0 + 32'd4);
    end else begin
      chk(nbeat == 1, "R3 single beat", 32'(nbeat), 1);
      chk(beat_a[0] == w0, "R3 beat address", beat_a[0], w0);
    end
    chk(beat_w[0] == wr, "R11 write flag", 32'(beat_w[0]), 32'(wr));
    if (wr) begin
      for (int k = 0; k < n; k++) refm[6'(a + 32'(k))] = sv[8*k +: 8];
      begin
        int bad = 0;
        for (int i = 0; i < 64; i++) if (mdl[i] !== refm[i]) bad++;
        chk(bad == 0, inject ? "R2 R5 memory after store" : "R5 memory after store",
            32'(bad), 0);
      end
    end else begin
      chk(got === expv, sw ? "R8 swapped load" : (sg ? "R7 signed load" : "R6 load"),
          got, expv);
      if (inject) begin
        int bad = 0;
        for (int i = 0; i < 64; i++) if (mdl[i] !== refm[i]) bad++;
        chk(bad == 0, "R2 ignored request", 32'(bad), 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) begin
      mdl[i] = 8'($urandom);
      refm[i] = mdl[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !rsp_valid && !mem_valid, "R1 reset outputs",
        {29'd0, busy, rsp_valid, mem_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !rsp_valid && !mem_valid, "R1 after reset",
        {29'd0, busy, rsp_valid, mem_valid}, 0);

    // directed corners
    run_op(1, 2'd2, 0, 0, 32'h0000_0000, 32'h8811_2280, 0);
    run_op(0, 2'd2, 0, 0, 32'h0000_0001, '0, 0);
    run_op(1, 2'd0, 0, 0, 32'h0000_0004, 32'h0000_00F0, 0);
    run_op(0, 2'd0, 1, 0, 32'h0000_0004, '0, 0);
    run_op(0, 2'd0, 0, 0, 32'h0000_0004, '0, 0);
    run_op(1, 2'd1, 0, 0, 32'h0000_0007, 32'h0000_9A55, 0);
    run_op(0, 2'd1, 1, 0, 32'h0000_0007, '0, 0);
    run_op(0, 2'd1, 0, 0, 32'h0000_0006, '0, 0);
    run_op(0, 2'd3, 0, 0, 32'h0000_000A, '0, 0);
    run_op(0, 2'd2, 0, 1, 32'h0000_0003, '0, 0);
    run_op(1, 2'd1, 0, 1, 32'h0000_0012, 32'hABCD_1234, 0);
    run_op(0, 2'd2, 0, 0, 32'hFFFF_FFFF, '0, 0);
    run_op(1, 2'd2, 0, 0, 32'hFFFF_FFFE, 32'h0102_0304, 0);
    run_op(0, 2'd2, 1, 0, 32'h0000_0002, '0, 1);

    for (int r = 0; r < 400; r++) begin
      logic [31:0] ra = {$urandom % 2 == 0 ? 26'h3FF_FFFF : 26'd0, 6'($urandom)};
      run_op(1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), ra,
             $urandom, ($urandom % 8) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule